// File: doc/BRIEF.md
# Fractional Baud Tick Prescaler

This block produces the bit-rate enable for a serial transmitter or a parallel output sequencer. It runs on a 48 MHz system clock. An internal 3 MHz reference enable is asserted once every 16 system cycles. The block divides that reference by an integer count plus a fraction in eighths. Each output period is a whole number of reference ticks. A three-bit fraction accumulator adds one reference tick to a period each time it wraps, so the fraction is spread evenly across the periods. The result is a one-cycle pulse whose long-term rate matches the requested divisor.

Two integer values are handled as special cases. An integer part of zero gives one tick per reference tick, which is 3 Mbaud. An integer part of one gives an average spacing of one and a half reference ticks, which is 2 Mbaud. In both cases the fraction input is ignored. The divisor inputs are captured only at a period boundary, so software can change them at any time without producing a short or merged pulse.

Top module: `baud_prescaler`

## Requirements
- R1: While reset is held, `baudTick` stays low. After reset is released, the divisor is first captured on the 16th system cycle. The first tick follows one full period after that capture, so with an integer part of 2 and a fraction of 0 the first tick is seen after the 48th rising edge.
- R2: The reference enable occurs exactly once every 16 system cycles. Every tick follows a reference enable, so tick spacings are whole multiples of 16 cycles.
- R3: Each tick is high for exactly one system clock cycle.
- R4: For an integer part n of 2 or more and a fraction of 0, every period lasts exactly n reference ticks.
- R5: For n of 2 or more and a fraction code f (0 to 7, meaning f/8), a 3-bit accumulator adds f at each boundary. A period lasts n reference ticks, plus one more when that addition carries out of 3 bits. Any 8 consecutive periods therefore total 8n+f reference ticks.
- R6: With n = 0, every period lasts one reference tick (16 system cycles) for any fraction code, and the accumulator is cleared.
- R7: With n = 1, the fraction input is ignored and a half step (code 4) is accumulated instead. Periods alternate between 1 and 2 reference ticks, so every 2 consecutive periods total 48 system cycles.
- R8: The divisor inputs are sampled only at the reference tick that ends a period (or at the first reference tick after reset). A change made inside a period does not alter that period's length. A change that is reverted before the boundary has no effect at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divInt | input | 14 | Integer part of the divisor (0 and 1 are special) |
| divFrac | input | 3 | Fraction of the divisor in eighths |
| baudTick | output | 1 | One-cycle bit-rate enable pulse |

## Verification
A wrong remaining-count or a wrong accumulator value shows up at the next tick after the bad boundary. The tick arrives 16 cycles early or late, or the 8-period span misses 16·(8n+f) cycles. A stuck or doubled reference enable moves every tick off the 16-cycle grid within one period. A premature capture of new divisor values moves the tick that ends the current period. Because of this, mid-period changes are checked against the old length first and the new length afterwards.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;

  // Divisor decode: integer part 0, integer part 1, general fractional case
  typedef enum logic [1:0] {
    DIV_FAST = 2'd0,
    DIV_HALF = 2'd1,
    DIV_FRAC = 2'd2
  } div_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic refEn;    // reference tick this cycle
    logic load;     // period boundary: capture divisor, reload counter
    logic step;     // reference tick inside a period: count down
    logic tickReq;  // boundary that ends a running period
  } strobe_t;

endpackage

// File: rtl/baud_ref_ctrl.sv
`timescale 1ns/1ps
module baud_ref_ctrl
  import baud_pkg::*;
#(
  parameter int REF_DIV = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    remLast,
  input  logic    remIdle,
  output strobe_t strb
);

  localparam int REF_W = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_DIV - 1);
  localparam bit REF_POW2 = ((REF_DIV & (REF_DIV - 1)) == 0);

  logic [REF_W-1:0] refCnt;
  logic [REF_W-1:0] refCntNext;
  logic refEn;

  assign refEn = (refCnt == REF_LAST);

  generate
    if (REF_POW2) begin : g_wrapFree
      assign refCntNext = refCnt + 1'b1;
    end else begin : g_wrapCmp
      assign refCntNext = refEn ? '0 : refCnt + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refCnt <= '0;
    else       refCnt <= refCntNext;
  end

  always_comb begin
    strb.refEn   = refEn;
    strb.load    = refEn && (remLast || remIdle);
    strb.tickReq = refEn && remLast;
    strb.step    = refEn && !(remLast || remIdle);
  end

  AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    strb.refEn |=> !strb.refEn); // R2

  AST_TICK_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.tickReq |-> strb.load); // R8

endmodule

// File: rtl/baud_period_calc.sv
`timescale 1ns/1ps
module baud_period_calc
  import baud_pkg::*;
#(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic [FRAC_W-1:0] accQ,
  output logic [INT_W:0]    lenNext,
  output logic [FRAC_W-1:0] accNext
);

  localparam int LEN_W = INT_W + 1;
  localparam logic [FRAC_W-1:0] FRAC_HALF = FRAC_W'(1) << (FRAC_W - 1);

  div_mode_e mode;
  logic [FRAC_W-1:0] effFrac;
  logic [FRAC_W:0] sum;
  logic [INT_W-1:0] baseInt;

  always_comb begin
    if (divInt == '0)                    mode = DIV_FAST;
    else if (divInt == INT_W'(1))        mode = DIV_HALF;
    else                                 mode = DIV_FRAC;

    case (mode)
      DIV_FAST: effFrac = '0;
      DIV_HALF: effFrac = FRAC_HALF;
      default:  effFrac = divFrac;
    endcase

    baseInt = (mode == DIV_FRAC) ? divInt : INT_W'(1);
    sum     = {1'b0, accQ} + {1'b0, effFrac};
    lenNext = {1'b0, baseInt} + {{(LEN_W-1){1'b0}}, sum[FRAC_W]};
    accNext = (mode == DIV_FAST) ? '0 : sum[FRAC_W-1:0];
  end

endmodule

// File: rtl/baud_frac_dp.sv
`timescale 1ns/1ps
module baud_frac_dp
  import baud_pkg::*;
#(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output logic              remLast,
  output logic              remIdle,
  output logic              baudTick
);

  localparam int LEN_W = INT_W + 1;

  logic [LEN_W-1:0]  remCnt;
  logic [FRAC_W-1:0] accQ;
  logic [LEN_W-1:0]  lenNext;
  logic [FRAC_W-1:0] accNext;

  baud_period_calc #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
  ) calc_i (
    .divInt  (divInt),
    .divFrac (divFrac),
    .accQ    (accQ),
    .lenNext (lenNext),
    .accNext (accNext)
  );

  assign remLast = (remCnt == LEN_W'(1));
  assign remIdle = (remCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt   <= '0;
      accQ     <= '0;
      baudTick <= 1'b0;
    end else begin
      baudTick <= strb.tickReq;
      if (strb.load) begin
        remCnt <= lenNext;
        accQ   <= accNext;
      end else if (strb.step) begin
        remCnt <= remCnt - 1'b1;
      end
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick); // R3

  AST_TICK_AFTER_REF: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> $past(strb.refEn)); // R2

  AST_HOLD_OFF_REF: assert property (@(posedge clk) disable iff (!rstN)
    !strb.refEn |=> $stable(remCnt) && $stable(accQ)); // R8

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (remCnt != '0)); // R5

  AST_STEP_ABOVE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (remCnt > LEN_W'(1))); // R4

  AST_FAST_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && divInt == '0) |=> (remCnt == LEN_W'(1) && accQ == '0)); // R6

  AST_HALF_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && divInt == INT_W'(1)) |=> (remCnt == LEN_W'(1) || remCnt == LEN_W'(2))); // R7

endmodule

// File: rtl/baud_prescaler.sv
`timescale 1ns/1ps
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int INT_W   = 14,
  parameter int FRAC_W  = 3,
  parameter int REF_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output logic              baudTick
);

  strobe_t strb;
  logic remLast;
  logic remIdle;

  baud_ref_ctrl #(
    .REF_DIV (REF_DIV)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .remLast (remLast),
    .remIdle (remIdle),
    .strb    (strb)
  );

  baud_frac_dp #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .divInt   (divInt),
    .divFrac  (divFrac),
    .remLast  (remLast),
    .remIdle  (remIdle),
    .baudTick (baudTick)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !baudTick); // R1

endmodule

// File: tb/baud_prescaler_tb_top.sv
`timescale 1ns/1ps
module baud_prescaler_tb_top;

  localparam int REF = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic [13:0] divInt;
  logic [2:0] divFrac;
  logic baudTick;

  baud_prescaler dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .divInt   (divInt),
    .divFrac  (divFrac),
    .baudTick (baudTick)
  );

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  longint cyc = 0;
  longint expQ[$];
  int mRem = 0;
  int mAcc = 0;
  int mSum = 0;
  bit prevTick = 1'b0;
  bit done = 1'b0;

  task automatic note(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expectation producer: pushes the cycle of each expected tick (R2, R4-R8)
  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; mRem = 0; mAcc = 0;
    end else begin
      cyc++;
      if (cyc % REF == 0) begin
        if (mRem == 1) expQ.push_back(cyc);
        if (mRem <= 1) begin
          if (divInt == 0) begin
            mRem = 1; mAcc = 0;
          end else begin
            mSum = mAcc + ((divInt == 1) ? 4 : int'(divFrac));
            mRem = ((divInt == 1) ? 1 : int'(divInt)) + mSum / 8;
            mAcc = mSum % 8;
          end
        end else begin
          mRem--;
        end
      end
    end
  end

  // Monitor: pops expectations and compares with observed ticks
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (baudTick) begin
        note(!prevTick, "R3", "tick width", longint'(prevTick), 0);
        if (expQ.size() == 0) note(1'b0, curReq, "unexpected tick", cyc, -1);
        else begin
          longint e;
          e = expQ.pop_front();
          note(e == cyc, curReq, "tick cycle", cyc, e);
        end
      end else if (expQ.size() > 0 && expQ[0] < cyc) begin
        note(1'b0, curReq, "missing tick", cyc, expQ[0]);
        void'(expQ.pop_front());
      end
      prevTick = baudTick;
    end
  end

  task automatic setDiv(int n, int f);
    @(negedge clk);
    divInt = 14'(n);
    divFrac = 3'(f);
  endtask

  task automatic waitTick(output longint t);
    do @(negedge clk); while (!baudTick);
    t = cyc;
  endtask

  task automatic spanCheck(string req, int n, int f);
    longint t0, t1;
    int nEff, fEff;
    curReq = req;
    nEff = (n == 0) ? 1 : n;
    fEff = (n == 0) ? 0 : ((n == 1) ? 4 : f);
    setDiv(n, f);
    waitTick(t0);
    note(t0 % REF == 0, "R2", "tick on reference grid", t0 % REF, 0);
    for (int i = 0; i < 8; i++) waitTick(t1);
    note(t1 - t0 == longint'(REF * (8 * nEff + fEff)), req, "8-period span", t1 - t0,
         longint'(REF * (8 * nEff + fEff)));
  endtask

  initial begin
    longint ta, tb, tc;
    rstN = 1'b0;
    divInt = 14'd2;
    divFrac = 3'd0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      note(baudTick == 1'b0, "R1", "tick during reset", longint'(baudTick), 0);
    end
    rstN = 1'b1;
    curReq = "R1";
    waitTick(ta);
    note(ta == 48, "R1", "first tick cycle", ta, 48);

    spanCheck("R4", 2, 0);
    spanCheck("R4", 7, 0);
    spanCheck("R5", 2, 7);
    spanCheck("R5", 5, 3);
    spanCheck("R5", 3, 4);
    spanCheck("R5", 10, 1);
    spanCheck("R6", 0, 0);
    spanCheck("R6", 0, 7);
    spanCheck("R7", 1, 0);
    spanCheck("R7", 1, 7);

    // R7: two consecutive periods are 16 and 32 cycles in some order
    waitTick(ta); waitTick(tb); waitTick(tc);
    note((tc - ta == 48) && (tb - ta != tc - tb), "R7", "alternating pair", tc - ta, 48);

    // R8: mid-period change keeps the running period, next one uses it
    curReq = "R8";
    setDiv(6, 0);
    waitTick(ta);
    waitTick(ta);
    repeat (40) @(negedge clk);
    divInt = 14'd3;
    waitTick(tb);
    note(tb - ta == 96, "R8", "period after mid change", tb - ta, 96);
    waitTick(tc);
    note(tc - tb == 48, "R8", "period with new divisor", tc - tb, 48);

    // R8: change reverted before the boundary has no effect
    setDiv(12, 0);
    waitTick(ta);
    waitTick(ta);
    repeat (30) @(negedge clk);
    divInt = 14'd2; divFrac = 3'd5;
    repeat (50) @(negedge clk);
    divInt = 14'd12; divFrac = 3'd0;
    waitTick(tb);
    note(tb - ta == 192, "R8", "reverted change ignored", tb - ta, 192);
    waitTick(tc);
    note(tc - tb == 192, "R8", "following period", tc - tb, 192);

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    checks++;
    failures++;
    $display("FAIL %s watchdog actual=%0d expected=%0d", curReq, cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule